// File: doc/BRIEF.md
# Hash Engine Command and Status Register Front End

This block is the software-facing register file of a hash accelerator. A host writes 32-bit words that hold the source address, the destination address, the key buffer address, the source length, a crypt command word and the hash command. Each value is trimmed by a mask that depends on the chip generation. The generation is picked by a parameter when the design is elaborated.

A write to the hash command word is decoded at once. If the algorithm selection is legal and the engine is idle, the block sends the engine a one-cycle start pulse. The pulse carries a compact algorithm code, the scatter-gather enable and the accumulate flag. When the engine reports completion, a sticky done bit is set in the status word. The interrupt line rises only if the command that started the job asked for it. Writing 1 to the done bit clears both the bit and the interrupt.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset, every register reads 0, the start pulse is low and the interrupt is low.
- R2: The word index is the byte address shifted right by two. The byte offsets are: crypt command 0x10 (all 32 bits stored), status 0x1C, source 0x20, destination 0x24, key 0x28, length 0x2C and hash command 0x30. Any other in-range word reads 0.
- R3: Written values are ANDed with a mask. Length always uses 0x0FFFFFFF. For VARIANT 2 the masks are: source 0x7FFFFFFF, destination 0x7FFFFFF8, key 0x7FFFFFF8, command 0x00147FFF. For VARIANT 0 they are: source 0x0FFFFFFF, destination 0x0FFFFFF8, key 0x0FFFFFC0, command 0x000003FF. VARIANT 1 is like VARIANT 0 with 0x3 in the top nibble of the three address masks.
- R4: The algorithm decode uses the masked command. Base field [6:4] selects 000 MD5, 010 SHA-1, 100 SHA-224, 101 SHA-256, and 110 the wide family. For the family, [12:10] selects 000 SHA-512, 001 SHA-384 and 010 SHA-256. For any other base, [12:10] must be 000. The output codes are MD5=0, SHA-1=1, SHA-224=2, SHA-256=3, SHA-512=4 and SHA-384=5.
- R5: A legal command written while idle makes eng_start high for exactly the cycle after the write. At the same time, eng_alg carries the code, eng_sg carries bit 18 and eng_acc is high when [8:7]=10.
- R6: A command with an illegal selection is stored and readable, but gives no start pulse.
- R7: While a job runs (from its start until eng_done), a further command write is stored but gives no start pulse.
- R8: eng_done during a job sets status bit 9 one cycle later, whatever the interrupt enable. eng_done with no job running is ignored.
- R9: irq rises together with the done bit only if bit 9 of the command that started the job was 1.
- R10: Writing status with bit 9 = 1 clears the done bit and irq. Writing 0 to bit 9 leaves both unchanged. A completion in the same cycle takes precedence over the clear.
- R11: A word index at or above NUM_REGS reads 0 and its writes change nothing. There is no aliasing onto the implemented words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for one register word |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| eng_start | output | 1 | One-cycle job start to the hash engine |
| eng_alg | output | 3 | Algorithm code of the started job |
| eng_sg | output | 1 | Scatter-gather enable of the started job |
| eng_acc | output | 1 | Accumulate-mode flag of the started job |
| eng_done | input | 1 | Job completion from the hash engine |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two copies. The first uses VARIANT 2, which keeps the scatter-gather bit and the [12:10] sub-select, so all 64 base/sub combinations can be swept with varied mode, scatter-gather and interrupt-enable bits. The second uses VARIANT 0: its narrow command mask erases the sub-select, which shows that a family request with stray upper bits becomes SHA-512, and its key mask differs in the low bits. NUM_REGS is 32 with a 12-bit address, so out-of-range words such as the one 32 words above the command word can be reached and checked for aliasing.

// File: rtl/hce_pkg.sv
package hce_pkg;

    localparam int WORD_CRYPT  = 4;
    localparam int WORD_STATUS = 7;
    localparam int WORD_SRC    = 8;
    localparam int WORD_DST    = 9;
    localparam int WORD_KEY    = 10;
    localparam int WORD_LEN    = 11;
    localparam int WORD_CMD    = 12;

    localparam int DONE_BIT   = 9;
    localparam int IRQEN_BIT  = 9;
    localparam int SG_BIT     = 18;
    localparam logic [31:0] LEN_MASK = 32'h0FFF_FFFF;

    typedef enum logic [2:0] {
        ALG_MD5    = 3'd0,
        ALG_SHA1   = 3'd1,
        ALG_SHA224 = 3'd2,
        ALG_SHA256 = 3'd3,
        ALG_SHA512 = 3'd4,
        ALG_SHA384 = 3'd5
    } hce_alg_e;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'b00,
        MODE_KEYED   = 2'b01,
        MODE_ACCUM   = 2'b10,
        MODE_KEYLOAD = 2'b11
    } hce_mode_e;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] key;
        logic [31:0] cmd;
    } hce_masks_t;

    typedef struct packed {
        logic     valid;
        hce_alg_e alg;
        logic     sg;
        logic     acc;
        logic     irq_en;
    } hce_req_t;

    function automatic hce_masks_t variant_masks(int unsigned v);
        hce_masks_t m;
        case (v)
            0: m = '{src: 32'h0FFF_FFFF, dst: 32'h0FFF_FFF8,
                     key: 32'h0FFF_FFC0, cmd: 32'h0000_03FF};
            1: m = '{src: 32'h3FFF_FFFF, dst: 32'h3FFF_FFF8,
                     key: 32'h3FFF_FFC0, cmd: 32'h0000_03FF};
            default: m = '{src: 32'h7FFF_FFFF, dst: 32'h7FFF_FFF8,
                           key: 32'h7FFF_FFF8, cmd: 32'h0014_7FFF};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hce_cmd_decode.sv
module hce_cmd_decode
    import hce_pkg::*;
(
    input  logic [31:0] cmd,
    output hce_req_t    req
);
    logic [2:0] base;
    logic [2:0] sub;
    logic       unused_bits;

    assign base = cmd[6:4];
    assign sub  = cmd[12:10];
    assign unused_bits = ^{cmd[31:19], cmd[17:13], cmd[3:0]};

    always_comb begin
        req        = '0;
        req.sg     = cmd[SG_BIT];
        req.acc    = (hce_mode_e'(cmd[8:7]) == MODE_ACCUM);
        req.irq_en = cmd[IRQEN_BIT];
        case (base)
            3'b000: begin req.alg = ALG_MD5;    req.valid = (sub == 3'b000); end
            3'b010: begin req.alg = ALG_SHA1;   req.valid = (sub == 3'b000); end
            3'b100: begin req.alg = ALG_SHA224; req.valid = (sub == 3'b000); end
            3'b101: begin req.alg = ALG_SHA256; req.valid = (sub == 3'b000); end
            3'b110: begin
                case (sub)
                    3'b000:  begin req.alg = ALG_SHA512; req.valid = 1'b1; end
                    3'b001:  begin req.alg = ALG_SHA384; req.valid = 1'b1; end
                    3'b010:  begin req.alg = ALG_SHA256; req.valid = 1'b1; end
                    default: begin req.alg = ALG_MD5;    req.valid = 1'b0; end
                endcase
            end
            default: begin req.alg = ALG_MD5; req.valid = 1'b0; end
        endcase
    end
endmodule

// File: rtl/hce_reg_file.sv
module hce_reg_file
    import hce_pkg::*;
#(
    parameter int unsigned VARIANT  = 2,
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              status_bit,
    output logic [31:0]       rdata,
    output logic              cmd_wr,
    output logic [31:0]       cmd_next,
    output logic              status_clr
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam hce_masks_t  MASKS = variant_masks(VARIANT);

    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             unused_lsb;
    logic [31:0]      crypt_q, src_q, dst_q, key_q, len_q, cmd_q;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];
    assign in_range   = ({22'd0, idx} < NUM_REGS);

    function automatic logic hit(input logic [IDX_W-1:0] i, input int w);
        return (i == IDX_W'(w));
    endfunction

    assign cmd_wr     = wr && in_range && hit(idx, WORD_CMD);
    assign cmd_next   = wdata & MASKS.cmd;
    assign status_clr = wr && in_range && hit(idx, WORD_STATUS) && wdata[DONE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            crypt_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            key_q   <= '0;
            len_q   <= '0;
            cmd_q   <= '0;
        end else if (wr && in_range) begin
            if (hit(idx, WORD_CRYPT)) crypt_q <= wdata;
            if (hit(idx, WORD_SRC))   src_q   <= wdata & MASKS.src;
            if (hit(idx, WORD_DST))   dst_q   <= wdata & MASKS.dst;
            if (hit(idx, WORD_KEY))   key_q   <= wdata & MASKS.key;
            if (hit(idx, WORD_LEN))   len_q   <= wdata & LEN_MASK;
            if (hit(idx, WORD_CMD))   cmd_q   <= cmd_next;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            if (hit(idx, WORD_CRYPT))  rdata = crypt_q;
            if (hit(idx, WORD_STATUS)) rdata[DONE_BIT] = status_bit;
            if (hit(idx, WORD_SRC))    rdata = src_q;
            if (hit(idx, WORD_DST))    rdata = dst_q;
            if (hit(idx, WORD_KEY))    rdata = key_q;
            if (hit(idx, WORD_LEN))    rdata = len_q;
            if (hit(idx, WORD_CMD))    rdata = cmd_q;
        end
    end
endmodule

// File: rtl/hce_issue_ctl.sv
module hce_issue_ctl
    import hce_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_wr,
    input  hce_req_t req,
    input  logic     done,
    input  logic     status_clr,
    output logic     start,
    output hce_alg_e alg,
    output logic     sg,
    output logic     acc,
    output logic     busy,
    output logic     status_bit,
    output logic     irq
);
    logic accept;
    logic finish;
    logic irq_en_q;

    assign accept = cmd_wr && req.valid && !busy;
    assign finish = done && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            start      <= 1'b0;
            alg        <= ALG_MD5;
            sg         <= 1'b0;
            acc        <= 1'b0;
            irq_en_q   <= 1'b0;
            busy       <= 1'b0;
            status_bit <= 1'b0;
            irq        <= 1'b0;
        end else begin
            start <= accept;
            if (accept) begin
                alg      <= req.alg;
                sg       <= req.sg;
                acc      <= req.acc;
                irq_en_q <= req.irq_en;
                busy     <= 1'b1;
            end else if (finish) begin
                busy <= 1'b0;
            end
            if (finish)          status_bit <= 1'b1;
            else if (status_clr) status_bit <= 1'b0;
            if (finish && irq_en_q) irq <= 1'b1;
            else if (status_clr)    irq <= 1'b0;
        end
    end
endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
    import hce_pkg::*;
#(
    parameter int unsigned VARIANT  = 2,
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              eng_start,
    output logic [2:0]        eng_alg,
    output logic              eng_sg,
    output logic              eng_acc,
    input  logic              eng_done,
    output logic              irq
);
    logic        cmd_wr;
    logic [31:0] cmd_next;
    logic        status_clr;
    logic        status_bit;
    logic        busy;
    hce_req_t    req;
    hce_alg_e    alg;

    hce_reg_file #(.VARIANT(VARIANT), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .status_bit(status_bit), .rdata(reg_rdata), .cmd_wr(cmd_wr),
        .cmd_next(cmd_next), .status_clr(status_clr)
    );

    hce_cmd_decode dec_i (.cmd(cmd_next), .req(req));

    hce_issue_ctl ctl_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .req(req), .done(eng_done),
        .status_clr(status_clr), .start(eng_start), .alg(alg), .sg(eng_sg),
        .acc(eng_acc), .busy(busy), .status_bit(status_bit), .irq(irq)
    );

    assign eng_alg = alg;
endmodule

// File: rtl/hce_checker.sv
module hce_checker
    import hce_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wdata_clr,
    input logic [31:0]       reg_rdata,
    input logic              eng_start,
    input logic              eng_done,
    input logic              irq,
    input logic              busy,
    input logic              status_bit
);
    logic [ADDR_W-3:0] idx;
    logic              is_status;
    logic              unused_lsb;
    assign idx        = reg_addr[ADDR_W-1:2];
    assign is_status  = (idx == (ADDR_W-2)'(WORD_STATUS));
    assign unused_lsb = ^reg_addr[1:0];

    AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ({22'd0, idx} >= NUM_REGS) |-> (reg_rdata == 32'd0)); // R11
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R5
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !$past(busy)); // R7
    AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        $rose(status_bit) |-> $past(eng_done && busy)); // R8
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> status_bit); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && is_status && wdata_clr && !(eng_done && busy)) |=> (!status_bit && !irq)); // R10
endmodule

bind hash_ctl_regs hce_checker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata_clr(reg_wdata[9]), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_done(eng_done), .irq(irq), .busy(busy), .status_bit(status_bit)
);

// File: tb/hash_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module hash_ctl_regs_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          eng_done = 1'b0;
    logic [31:0]   rd_n, rd_o;
    logic          st_n, sg_n, acc_n, irq_n;
    logic          st_o, sg_o, acc_o, irq_o;
    logic [2:0]    alg_n, alg_o;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    hash_ctl_regs #(.VARIANT(2), .NUM_REGS(32), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_n), .eng_start(st_n), .eng_alg(alg_n), .eng_sg(sg_n),
        .eng_acc(acc_n), .eng_done(eng_done), .irq(irq_n));

    hash_ctl_regs #(.VARIANT(0), .NUM_REGS(32), .ADDR_W(AW)) dut_old_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_o), .eng_start(st_o), .eng_alg(alg_o), .eng_sg(sg_o),
        .eng_acc(acc_o), .eng_done(eng_done), .irq(irq_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] a);
        reg_addr = a;
        #0.5;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // expected decode from the requirement table: {sub,base} -> code
    function automatic logic [3:0] expect_alg(input int b, input int s);
        int key;
        key = s * 8 + b;
        if (key == 0)  return 4'h8;       // MD5
        if (key == 2)  return 4'h9;       // SHA-1
        if (key == 4)  return 4'hA;       // SHA-224
        if (key == 5)  return 4'hB;       // SHA-256
        if (key == 6)  return 4'hC;       // SHA-512
        if (key == 14) return 4'hD;       // SHA-384
        if (key == 22) return 4'hB;       // SHA-256 via family
        return 4'h0;                       // bit3 = valid
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int w = 0; w < 16; w++) begin
            peek(AW'(w * 4));
            check("R1 reset read", rd_n, 32'd0);
        end
        check("R1 start low", {31'd0, st_n}, 32'd0);
        check("R1 irq low", {31'd0, irq_n}, 32'd0);

        // R2 / R3 offsets and masks
        wr_reg(12'h010, 32'hFFFF_FFFF);
        wr_reg(12'h020, 32'hFFFF_FFFF);
        wr_reg(12'h024, 32'hFFFF_FFFF);
        wr_reg(12'h028, 32'hFFFF_FFFF);
        wr_reg(12'h02C, 32'hFFFF_FFFF);
        wr_reg(12'h030, 32'hFFFF_FFFF);
        check("R6 no start on illegal all-ones", {31'd0, st_n}, 32'd0);
        peek(12'h010); check("R2 crypt word", rd_n, 32'hFFFF_FFFF);
        peek(12'h020); check("R3 src v2", rd_n, 32'h7FFF_FFFF);
        check("R3 src v0", rd_o, 32'h0FFF_FFFF);
        peek(12'h024); check("R3 dst v2", rd_n, 32'h7FFF_FFF8);
        check("R3 dst v0", rd_o, 32'h0FFF_FFF8);
        peek(12'h028); check("R3 key v2", rd_n, 32'h7FFF_FFF8);
        check("R3 key v0", rd_o, 32'h0FFF_FFC0);
        peek(12'h02C); check("R3 len v2", rd_n, 32'h0FFF_FFFF);
        check("R3 len v0", rd_o, 32'h0FFF_FFFF);
        peek(12'h030); check("R6 cmd stored v2", rd_n, 32'h0014_7FFF);
        check("R3 cmd v0", rd_o, 32'h0000_03FF);
        wr_reg(12'h034, 32'h1234_5678);
        peek(12'h034); check("R2 unused word reads zero", rd_n, 32'd0);
        peek(12'h022); check("R2 byte offset ignored", rd_n, 32'h7FFF_FFFF);

        // R11 out of range: index 44 must not alias command word 12
        wr_reg(12'h0B0, 32'h0000_0020);
        check("R11 oor write no start", {31'd0, st_n}, 32'd0);
        peek(12'h0B0); check("R11 oor read zero", rd_n, 32'd0);
        peek(12'h030); check("R11 cmd untouched", rd_n, 32'h0014_7FFF);

        // R4/R5/R6/R8/R9/R10 sweep over all base/sub combinations
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 8; s++) begin
                logic [3:0]  e;
                logic [31:0] d;
                int mode, sgb, ie;
                mode = (b + s) % 4;
                sgb  = (s >> 1) & 1;
                ie   = (b ^ s) & 1;
                e    = expect_alg(b, s);
                d    = (b << 4) | (s << 10) | (mode << 7) | (sgb << 18) | (ie << 9);
                wr_reg(12'h030, d);
                check(e[3] ? "R5 start on legal" : "R6 no start on illegal", {31'd0, st_n}, {31'd0, e[3]});
                if (e[3]) begin
                    check("R4 alg code", {29'd0, alg_n}, {29'd0, e[2:0]});
                    check("R5 sg flag", {31'd0, sg_n}, sgb);
                    check("R5 acc flag", {31'd0, acc_n}, {31'd0, mode == 2});
                end
                peek(12'h030); check("R6 cmd readback", rd_n, d);
                @(negedge clk);
                check("R5 start one cycle", {31'd0, st_n}, 32'd0);
                if (e[3]) begin
                    pulse_done();
                    peek(12'h01C);
                    check("R8 status set", rd_n, 32'h200);
                    check("R9 irq follows enable", {31'd0, irq_n}, ie);
                    wr_reg(12'h01C, 32'h0000_0200);
                    peek(12'h01C);
                    check("R10 status cleared", rd_n, 32'd0);
                    check("R10 irq cleared", {31'd0, irq_n}, 32'd0);
                end
            end
        end
        // settle old instance (may hold a job) with one done
        pulse_done();
        wr_reg(12'h01C, 32'h200);

        // R8 done while idle ignored
        pulse_done();
        peek(12'h01C); check("R8 idle done ignored", rd_n, 32'd0);

        // R7 busy blocks second start
        wr_reg(12'h030, 32'h0000_0250);
        check("R7 first start", {31'd0, st_n}, 32'd1);
        wr_reg(12'h030, 32'h0000_0020);
        check("R7 no start while busy", {31'd0, st_n}, 32'd0);
        peek(12'h030); check("R7 busy write stored", rd_n, 32'h20);
        // R10 write 0 no effect, done wins over clear
        @(negedge clk);
        eng_done = 1'b1; reg_wr = 1'b1; reg_addr = 12'h01C; reg_wdata = 32'h200;
        @(negedge clk);
        eng_done = 1'b0; reg_wr = 1'b0;
        peek(12'h01C); check("R10 done beats clear", rd_n, 32'h200);
        check("R10 irq set despite clear", {31'd0, irq_n}, 32'd1);
        wr_reg(12'h01C, 32'h0);
        peek(12'h01C); check("R10 zero write keeps status", rd_n, 32'h200);
        check("R10 zero write keeps irq", {31'd0, irq_n}, 32'd1);
        wr_reg(12'h01C, 32'h200);
        wr_reg(12'h030, 32'h0000_0020);
        check("R7 start after done", {31'd0, st_n}, 32'd1);
        check("R4 SHA-1 code", {29'd0, alg_n}, 32'd1);
        pulse_done();
        check("R9 no irq without enable", {31'd0, irq_n}, 32'd0);
        wr_reg(12'h01C, 32'h200);

        // R3/R4 narrow command mask drops sub-select and sg on VARIANT 0
        wr_reg(12'h030, 32'h0004_0460);
        check("R4 v0 start", {31'd0, st_o}, 32'd1);
        check("R4 v0 family becomes SHA-512", {29'd0, alg_o}, 32'd4);
        check("R3 v0 sg masked", {31'd0, sg_o}, 32'd0);
        check("R4 v2 SHA-384", {29'd0, alg_n}, 32'd5);
        check("R5 v2 sg", {31'd0, sg_n}, 32'd1);
        pulse_done();

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        peek(12'h01C); check("R1 status after reset", rd_n, 32'd0);
        peek(12'h020); check("R1 src after reset", rd_n, 32'd0);
        check("R1 irq after reset", {31'd0, irq_n}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule